// File: doc/BRIEF.md
# Tagged Time-Ordered Trigger Merger

This block gathers trigger records arriving on several parallel front-end streams and sends them out on one stream. Every record holds a trigger payload and a timestamp. Each input has a small first-in first-out buffer that pushes back on its source when full, so no record is ever lost. Whenever the output has finished its previous group of records, the block takes the oldest waiting record from every non-empty buffer at once. It stamps each one with the index of the input it came from and passes the group through a fixed compare-exchange network. It then hands the records out one at a time, earliest timestamp first, over a valid/ready handshake.

An input that has nothing waiting is filled into the network with a dummy entry that always sorts last, and dummy entries never leave the block. The payload and timestamp pass through unchanged. The only thing added is the origin index.

Top module: `tom_merger`

## Requirements
- R1: After reset, `out_valid` is 0 and every bit of `in_ready` is 1.
- R2: Each input buffer holds up to DEPTH records. `in_ready[i]` is 1 exactly when input i holds fewer than DEPTH records. A record is accepted on a clock edge where `in_valid[i]` and `in_ready[i]` are both 1, and an accepted record is never dropped.
- R3: A new group is formed on an edge where at least one buffer is non-empty and either no record is pending at the output, or the only pending record is leaving on that edge. The head record of every non-empty buffer is removed on that edge, and the first record of the group is on the output in the following cycle.
- R4: Within a group, records leave in ascending timestamp order. When two timestamps are equal, the record with the lower origin index leaves first.
- R5: `out_tag` equals the index of the input that delivered the record. `out_ts` and `out_trig` equal the values given at that input.
- R6: A group contains exactly one record per input that was non-empty when the group was formed. Inputs with nothing waiting produce no output record.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_ts`, `out_tag` and `out_trig` stay unchanged on the next cycle.
- R8: Records from the same input leave in the order they were accepted, and the total number of records leaving equals the number accepted once the block has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | Record offered on each input |
| in_ready | output | N_IN | Input buffer can accept a record |
| in_trig | input | N_IN*TRIG_W | Trigger payload per input, input i at bits i*TRIG_W |
| in_ts | input | N_IN*TS_W | Timestamp per input, input i at bits i*TS_W |
| out_valid | output | 1 | Merged record available |
| out_ready | input | 1 | Downstream accepts the record |
| out_trig | output | TRIG_W | Trigger payload of the merged record |
| out_ts | output | TS_W | Timestamp of the merged record |
| out_tag | output | max(1,clog2(N_IN)) | Index of the originating input |

## Verification
The hardest case to reach from the ports is the one where every input buffer is full at once, so that `in_ready` drops while groups are still draining. The same goes for a group being loaded on the very edge its predecessor's last record leaves. The stimulus reaches these by holding `out_ready` mostly low for a long stretch while all sources offer records on most cycles, and later by draining with `out_ready` high. A stretch with timestamps drawn from only four values forces equal keys, so the tie-break by origin index is exercised. A stretch with only some inputs active produces partial groups.

// File: rtl/tom_pkg.sv
package tom_pkg;

  // width of an index able to name n distinct items
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tom_fifo.sv
module tom_fifo #(
  parameter int unsigned W     = 20,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          do_push, do_pop;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/tom_sortnet.sv
module tom_sortnet #(
  parameter int unsigned N  = 4,
  parameter int unsigned EW = 23,
  parameter int unsigned KW = 15
) (
  input  logic [EW-1:0] din  [N],
  output logic [EW-1:0] dout [N]
);
  // odd-even transposition: N layers of compare-exchange on the upper KW bits
  logic [EW-1:0] lane [N+1][N];

  for (genvar j = 0; j < N; j++) begin : g_in
    assign lane[0][j] = din[j];
    assign dout[j]    = lane[N][j];
  end

  for (genvar s = 0; s < N; s++) begin : g_layer
    for (genvar j = 0; j < N; j++) begin : g_cell
      if (((j % 2) == (s % 2)) && (j + 1 < N)) begin : g_lo
        assign lane[s+1][j] = (lane[s][j][EW-1 -: KW] <= lane[s][j+1][EW-1 -: KW])
                              ? lane[s][j] : lane[s][j+1];
      end else if (((j % 2) != (s % 2)) && (j >= 1)) begin : g_hi
        assign lane[s+1][j] = (lane[s][j-1][EW-1 -: KW] <= lane[s][j][EW-1 -: KW])
                              ? lane[s][j] : lane[s][j-1];
      end else begin : g_pass
        assign lane[s+1][j] = lane[s][j];
      end
    end
  end
endmodule

// File: rtl/tom_emit.sv
module tom_emit #(
  parameter int unsigned N  = 4,
  parameter int unsigned SW = 23
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  avail,
  input  logic [SW-1:0] ranked [N],
  input  logic          out_ready,
  output logic          out_valid,
  output logic [SW-2:0] out_data,
  output logic          load,
  output logic [N-1:0]  pop
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam int unsigned RW = SW - 1;

  logic [CW-1:0] left;
  logic [RW-1:0] slot [N];
  logic          fire;
  logic [CW-1:0] real_cnt;

  assign out_valid = (left != '0);
  assign out_data  = slot[0];
  assign fire      = out_valid && out_ready;
  assign load      = (|avail) && ((left == '0) || ((left == CW'(1)) && out_ready));
  assign pop       = load ? avail : '0;

  // non-sentinel entries carry a clear top bit
  always_comb begin
    real_cnt = '0;
    for (int k = 0; k < N; k++) real_cnt = real_cnt + CW'(!ranked[k][SW-1]);
  end

  always_ff @(posedge clk) begin
    if (rst)       left <= '0;
    else if (load) left <= real_cnt;
    else if (fire) left <= left - 1'b1;
  end

  for (genvar k = 0; k < N; k++) begin : g_slot
    if (k < N - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (load)      slot[k] <= ranked[k][RW-1:0];
        else if (fire) slot[k] <= slot[k+1];
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (load) slot[k] <= ranked[k][RW-1:0];
      end
    end
  end
endmodule

// File: rtl/tom_merger.sv
module tom_merger #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned TS_W   = 12,
  parameter int unsigned TRIG_W = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned TAG_W  = tom_pkg::idx_bits(N_IN)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN-1:0]          in_valid,
  output logic [N_IN-1:0]          in_ready,
  input  logic [N_IN*TRIG_W-1:0]   in_trig,
  input  logic [N_IN*TS_W-1:0]     in_ts,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [TRIG_W-1:0]        out_trig,
  output logic [TS_W-1:0]          out_ts,
  output logic [TAG_W-1:0]         out_tag
);
  localparam int unsigned DW = TS_W + TRIG_W;
  localparam int unsigned RW = TS_W + TAG_W + TRIG_W;
  localparam int unsigned SW = RW + 1;
  localparam int unsigned KW = 1 + TS_W + TAG_W;

  logic [N_IN-1:0] fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic [DW-1:0]   head    [N_IN];
  logic [SW-1:0]   sort_in [N_IN];
  logic [SW-1:0]   sort_out[N_IN];
  logic [RW-1:0]   emit_data;
  logic            batch_load;

  for (genvar i = 0; i < N_IN; i++) begin : g_src
    assign fifo_push[i] = in_valid[i] && !fifo_full[i];
    assign in_ready[i]  = !fifo_full[i];

    tom_fifo #(.W(DW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (fifo_push[i]),
      .din   ({in_ts[i*TS_W +: TS_W], in_trig[i*TRIG_W +: TRIG_W]}),
      .pop   (fifo_pop[i]),
      .dout  (head[i]),
      .full  (fifo_full[i]),
      .empty (fifo_empty[i])
    );

    // key = {sentinel, timestamp, origin}; sentinel sorts after every real record
    assign sort_in[i] = fifo_empty[i]
      ? {1'b1, {TS_W{1'b1}}, TAG_W'(i), {TRIG_W{1'b0}}}
      : {1'b0, head[i][DW-1 -: TS_W], TAG_W'(i), head[i][TRIG_W-1:0]};
  end

  tom_sortnet #(.N(N_IN), .EW(SW), .KW(KW)) u_net (
    .din  (sort_in),
    .dout (sort_out)
  );

  tom_emit #(.N(N_IN), .SW(SW)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .avail     (~fifo_empty),
    .ranked    (sort_out),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (emit_data),
    .load      (batch_load),
    .pop       (fifo_pop)
  );

  assign out_ts   = emit_data[RW-1 -: TS_W];
  assign out_tag  = emit_data[TRIG_W +: TAG_W];
  assign out_trig = emit_data[TRIG_W-1:0];
endmodule

// File: rtl/tom_merger_chk.sv
module tom_merger_chk #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned TS_W   = 12,
  parameter int unsigned TRIG_W = 8,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned TAG_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_IN-1:0]   in_valid,
  input logic [N_IN-1:0]   in_ready,
  input logic [N_IN-1:0]   pop,
  input logic              load,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TS_W-1:0]   out_ts,
  input logic [TAG_W-1:0]  out_tag,
  input logic [TRIG_W-1:0] out_trig
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [TS_W+TAG_W-1:0] prev_key;
  logic                  same_grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      same_grp <= 1'b0;
      prev_key <= '0;
    end else if (load) begin
      same_grp <= 1'b0;
    end else if (out_valid && out_ready) begin
      same_grp <= 1'b1;
      prev_key <= {out_ts, out_tag};
    end
  end

  AST_GROUP_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && same_grp) |-> ({out_ts, out_tag} > prev_key)); // R4

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ts) && $stable(out_tag) && $stable(out_trig))); // R7

  AST_LOAD_DRAINED: assert property (@(posedge clk) disable iff (rst)
    load |-> (!out_valid || out_ready)); // R3

  for (genvar i = 0; i < N_IN; i++) begin : g_occ
    logic [CW-1:0] occ;
    always_ff @(posedge clk) begin
      if (rst) occ <= '0;
      else     occ <= occ + CW'(in_valid[i] && in_ready[i]) - CW'(pop[i]);
    end

    AST_READY_OCC: assert property (@(posedge clk) disable iff (rst)
      in_ready[i] == (occ < CW'(DEPTH))); // R2

    AST_POP_HELD: assert property (@(posedge clk) disable iff (rst)
      pop[i] |-> (occ != '0)); // R6
  end
endmodule

bind tom_merger tom_merger_chk #(
  .N_IN(N_IN), .TS_W(TS_W), .TRIG_W(TRIG_W), .DEPTH(DEPTH), .TAG_W(TAG_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .pop       (fifo_pop),
  .load      (batch_load),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_ts    (out_ts),
  .out_tag   (out_tag),
  .out_trig  (out_trig)
);

// File: tb/sim_tom_merger.sv
`timescale 1ns/1ps
module sim_tom_merger;
  localparam int unsigned N_IN   = 4;
  localparam int unsigned TS_W   = 12;
  localparam int unsigned TRIG_W = 8;
  localparam int unsigned DEPTH  = 4;
  localparam int unsigned TAG_W  = 2;
  localparam int unsigned RW     = TS_W + TAG_W + TRIG_W;

  logic                   clk = 1'b0;
  logic                   rst;
  logic [N_IN-1:0]        in_valid;
  logic [N_IN-1:0]        in_ready;
  logic [N_IN*TRIG_W-1:0] in_trig;
  logic [N_IN*TS_W-1:0]   in_ts;
  logic                   out_valid;
  logic                   out_ready;
  logic [TRIG_W-1:0]      out_trig;
  logic [TS_W-1:0]        out_ts;
  logic [TAG_W-1:0]       out_tag;

  always #4 clk = ~clk;

  tom_merger #(.N_IN(N_IN), .TS_W(TS_W), .TRIG_W(TRIG_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_trig(in_trig), .in_ts(in_ts), .out_valid(out_valid), .out_ready(out_ready),
    .out_trig(out_trig), .out_ts(out_ts), .out_tag(out_tag)
  );

  // behavioural reference: record = {ts, origin, trig}
  logic [RW-1:0] mq [N_IN][$];
  logic [RW-1:0] bq [$];

  int n_cmp = 0;
  int n_bad = 0;
  int n_acc = 0;
  int n_out = 0;
  bit done  = 1'b0;
  bit stalled = 1'b0;

  task automatic cmp(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_ports(input string tag_valid, input string tag_data);
    logic [RW-1:0] got;
    cmp(out_valid == (bq.size() != 0), tag_valid, 64'(out_valid), 64'(bq.size() != 0));
    if (bq.size() != 0 && out_valid) begin
      got = {out_ts, out_tag, out_trig};
      cmp(got == bq[0], tag_data, 64'(got), 64'(bq[0]));
    end
    for (int i = 0; i < N_IN; i++)
      cmp(in_ready[i] == (mq[i].size() < DEPTH), "R2 ready", 64'(in_ready[i]), 64'(mq[i].size() < DEPTH));
  endtask

  // advance reference by one edge using the inputs now driven
  task automatic step_model();
    bit rdy [N_IN];
    bit any_rec, fire, load;
    logic [RW-1:0] grp [$];
    logic [RW-1:0] e;
    int pos;
    any_rec = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      rdy[i] = (mq[i].size() < DEPTH);
      if (mq[i].size() != 0) any_rec = 1'b1;
    end
    fire = (bq.size() != 0) && out_ready;
    load = any_rec && ((bq.size() == 0) || ((bq.size() == 1) && out_ready));
    if (fire) begin
      void'(bq.pop_front());
      n_out++;
    end
    if (load) begin
      for (int i = 0; i < N_IN; i++) begin
        if (mq[i].size() != 0) begin
          e = mq[i].pop_front();
          pos = grp.size();
          for (int k = 0; k < grp.size(); k++) begin
            if (grp[k][RW-1:TRIG_W] > e[RW-1:TRIG_W]) begin
              pos = k;
              break;
            end
          end
          grp.insert(pos, e);
        end
      end
      foreach (grp[k]) bq.push_back(grp[k]);
    end
    for (int i = 0; i < N_IN; i++) begin
      if (in_valid[i] && rdy[i]) begin
        mq[i].push_back({in_ts[i*TS_W +: TS_W], TAG_W'(i), in_trig[i*TRIG_W +: TRIG_W]});
        n_acc++;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int vpct, rpct;
    rst = 1'b1;
    in_valid = '0;
    in_trig = '0;
    in_ts = '0;
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle output and open inputs straight after reset
    cmp(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    cmp(in_ready == '1, "R1 in_ready", 64'(in_ready), 64'(N_IN'('1)));

    for (int c = 0; c < 4000; c++) begin
      check_ports("R3 R6 valid", stalled ? "R7 held data" : "R4 R5 R8 data");
      if (c < 1000)      begin vpct = 50; rpct = 90; end
      else if (c < 2000) begin vpct = 80; rpct = 10; end
      else if (c < 3000) begin vpct = 60; rpct = 70; end
      else if (c < 3500) begin vpct = 60; rpct = 50; end
      else               begin vpct = 0;  rpct = 100; end
      for (int i = 0; i < N_IN; i++) begin
        in_valid[i] = ($urandom_range(99) < vpct);
        if (c >= 3000 && c < 3500 && (i % 2 == 1)) in_valid[i] = 1'b0; // R6 partial groups
        in_trig[i*TRIG_W +: TRIG_W] = TRIG_W'($urandom);
        in_ts[i*TS_W +: TS_W] = (c >= 2000 && c < 3000) ? TS_W'($urandom_range(3)) : TS_W'($urandom);
      end
      out_ready = ($urandom_range(99) < rpct);
      stalled = out_valid && !out_ready;
      step_model();
      @(negedge clk);
    end

    // R8: everything accepted has left, nothing pending anywhere
    cmp(out_valid == 1'b0, "R8 drained", 64'(out_valid), 64'd0);
    cmp(n_out == n_acc, "R8 count", 64'(n_out), 64'(n_acc));
    cmp(in_ready == '1, "R2 empty again", 64'(in_ready), 64'(N_IN'('1)));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule